// File: doc/BRIEF.md
# Integer Execute Unit with Barrel Shifter

This block is the purely combinational execute stage of a 32-bit load/store integer datapath. Each cycle it is given the fetched instruction word and the values already read for its two source register fields. It decodes the opcode and function fields itself and returns the computed value, the destination register index, and a write strobe for the register file. It also returns two exception indications: a signed-overflow trap and an unsupported-instruction flag.

The unit covers these operations:
- add, subtract, bitwise logic and set-on-less-than, in both register-register and register-immediate form;
- shifts by a constant amount taken from the instruction, or by a variable amount taken from a register;
- loading an immediate into the upper half of the word.

Memory access, multiply/divide and control transfer belong to other units. Any encoding outside the set below is reported as unsupported and never produces a write.

Instruction fields:
- For register-register words: opcode in bits 31:26, first source index (S) in bits 25:21, second source index (T) in bits 20:16, destination index (D) in bits 15:11, constant shift amount in bits 10:6, function code in bits 5:0.
- For immediate words: opcode, S and T sit in the same places, and a 16-bit immediate occupies bits 15:0.

Operand `rsVal` is the value of register S and `rtVal` is the value of register T.

Top module: `int_exec_unit`

## Requirements
- R1: Opcode 0x00 selects a register-register operation by its function code and reports D (bits 15:11) as the destination. Every immediate opcode reports T (bits 20:16) as the destination. For constant-amount shifts the S field and `rsVal` have no effect on the result.
- R2: Function 0x20 (add), function 0x22 (subtract) and opcode 0x08 (add immediate) trap on signed overflow. On overflow `ovfFlag` is 1 and `wrEn` is 0, while `result` still carries the wrapped value.
- R3: Function 0x21, function 0x23 and opcode 0x09 are the non-trapping forms of add, subtract and add-immediate. They wrap modulo 2^32 and never raise `ovfFlag`.
- R4: The bitwise functions are 0x24 AND, 0x25 OR, 0x26 XOR and 0x27 NOR (the inverse of the OR). The immediate opcodes 0x0C AND, 0x0D OR and 0x0E XOR zero-extend the immediate.
- R5: Opcodes 0x08, 0x09, 0x0A and 0x0B sign-extend the 16-bit immediate from its bit 15.
- R6: The set-on-less-than forms produce 32'h1 when true and 32'h0 when false. Function 0x2A and opcode 0x0A compare as signed; function 0x2B and opcode 0x0B compare as unsigned.
- R7: The constant shifts are function 0x00 (left), 0x02 (right with zero fill) and 0x03 (right, copying bit 31 into the vacated positions). Each shifts `rtVal` by bits 10:6 of the instruction.
- R8: The variable shifts are function 0x04 (left), 0x06 (right with zero fill) and 0x07 (right, copying bit 31). Each shifts `rtVal` by the low 5 bits of `rsVal`, and the instruction's shift-amount field is ignored.
- R9: Opcode 0x0F places the 16-bit immediate in result bits 31:16 and zeros in bits 15:0.
- R10: A legal operation whose destination index is 0 gives `wrEn` 0. The all-zero word is a legal no-operation: no write, no overflow, not unsupported.
- R11: Any other opcode or function code raises `illegalOp`, holds `wrEn` and `ovfFlag` at 0, and reports destination index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instrWord | input | 32 | Instruction word to execute |
| rsVal | input | XLEN | Value of the register named by bits 25:21 |
| rtVal | input | XLEN | Value of the register named by bits 20:16 |
| result | output | XLEN | Computed value |
| wrEn | output | 1 | Register file write strobe |
| destIdx | output | 5 | Destination register index |
| ovfFlag | output | 1 | Signed overflow trap on a trapping add or subtract |
| illegalOp | output | 1 | Unsupported encoding |

## Verification
The bench builds the unit with its default XLEN of 32, the width the instruction fields assume. At that width bit 31 is both the sign bit for overflow and compare and the fill bit for arithmetic shifts, and 31 is the largest shift amount, so the boundary operands 32'h7FFFFFFF, 32'h80000000 and 32'hFFFFFFFF exercise every trapping, wrapping, sign-extension and fill case. The variable-shift checks put nonzero values in the upper bits of `rsVal` and in the shift-amount field, which shows that only the intended 5-bit amount source is used.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
  } aluOp_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    aluOp_e op;
    logic   useImm;     // second operand is the immediate
    logic   zeroExt;    // immediate is zero-extended
    logic   varShift;   // shift amount comes from rsVal
    logic   signedCmp;  // signed compare
    logic   trapOvf;    // signed overflow traps
    logic   destIsRt;   // destination is the T field
    logic   legal;      // encoding recognised
  } ctrl_t;

endpackage

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import int_exec_pkg::*;
(
  input  logic [31:0] instrWord,
  output ctrl_t       ctrl
);

  logic [5:0] opcode;
  logic [5:0] funct;

  assign opcode = instrWord[31:26];
  assign funct  = instrWord[5:0];

  always_comb begin
    ctrl    = '0;
    ctrl.op = ALU_ADD;
    unique case (opcode)
      6'h00: begin
        ctrl.legal = 1'b1;
        case (funct)
          6'h20: ctrl.trapOvf = 1'b1;
          6'h21: ;
          6'h22: begin ctrl.op = ALU_SUB; ctrl.trapOvf = 1'b1; end
          6'h23: ctrl.op = ALU_SUB;
          6'h24: ctrl.op = ALU_AND;
          6'h25: ctrl.op = ALU_OR;
          6'h26: ctrl.op = ALU_XOR;
          6'h27: ctrl.op = ALU_NOR;
          6'h2A: begin ctrl.op = ALU_SLT; ctrl.signedCmp = 1'b1; end
          6'h2B: ctrl.op = ALU_SLT;
          6'h00: ctrl.op = ALU_SLL;
          6'h02: ctrl.op = ALU_SRL;
          6'h03: ctrl.op = ALU_SRA;
          6'h04: begin ctrl.op = ALU_SLL; ctrl.varShift = 1'b1; end
          6'h06: begin ctrl.op = ALU_SRL; ctrl.varShift = 1'b1; end
          6'h07: begin ctrl.op = ALU_SRA; ctrl.varShift = 1'b1; end
          default: ctrl.legal = 1'b0;
        endcase
      end
      6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E, 6'h0F: begin
        ctrl.legal    = 1'b1;
        ctrl.useImm   = 1'b1;
        ctrl.destIsRt = 1'b1;
        case (opcode[2:0])
          3'h0: ctrl.trapOvf = 1'b1;
          3'h1: ;
          3'h2: begin ctrl.op = ALU_SLT; ctrl.signedCmp = 1'b1; end
          3'h3: ctrl.op = ALU_SLT;
          3'h4: begin ctrl.op = ALU_AND; ctrl.zeroExt = 1'b1; end
          3'h5: begin ctrl.op = ALU_OR;  ctrl.zeroExt = 1'b1; end
          3'h6: begin ctrl.op = ALU_XOR; ctrl.zeroExt = 1'b1; end
          default: ctrl.op = ALU_LUI;
        endcase
      end
      default: ctrl.legal = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown(instrWord) && instrWord == 32'h0) begin
      AST_NOP_IS_LEGAL_SHIFT: assert (ctrl.legal && ctrl.op == ALU_SLL && !ctrl.trapOvf); // R10
    end
    if (!$isunknown(instrWord) && ctrl.trapOvf) begin
      AST_TRAP_ONLY_ADDSUB: assert (ctrl.op == ALU_ADD || ctrl.op == ALU_SUB); // R2
    end
  end

endmodule

// File: rtl/exec_shifter.sv
module exec_shifter #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] src,
  input  logic [SHW-1:0]  amt,
  input  logic            dirLeft,
  input  logic            arith,
  output logic [XLEN-1:0] dst
);

  logic fill;
  assign fill = arith & src[XLEN-1];

  // Logarithmic shifter: stage s moves by 2**s when amt[s] is set
  always_comb begin
    logic [XLEN-1:0] stage;
    stage = src;
    for (int s = 0; s < SHW; s++) begin
      if (amt[s]) begin
        if (dirLeft) begin
          stage = stage << (1 << s);
        end else begin
          stage = (stage >> (1 << s)) |
                  (fill ? ~({XLEN{1'b1}} >> (1 << s)) : {XLEN{1'b0}});
        end
      end
    end
    dst = stage;
  end

  always_comb begin
    if (!$isunknown({src, amt, dirLeft, arith}) && !dirLeft && arith && src[XLEN-1]) begin
      AST_SRA_KEEPS_SIGN: assert (dst[XLEN-1]); // R7
    end
  end

endmodule

// File: rtl/exec_datapath.sv
module exec_datapath
  import int_exec_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN),
  localparam int MSB = XLEN - 1
) (
  input  ctrl_t           ctrl,
  input  logic [15:0]     imm,
  input  logic [4:0]      shamt,
  input  logic [XLEN-1:0] rsVal,
  input  logic [XLEN-1:0] rtVal,
  output logic [XLEN-1:0] result,
  output logic            rawOvf
);

  logic [XLEN-1:0] immExt;
  logic [XLEN-1:0] opnd2;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] diff;
  logic [XLEN-1:0] shiftOut;
  logic [SHW-1:0]  shAmt;
  logic            lessThan;
  logic            addOvf;
  logic            subOvf;

  assign immExt = ctrl.zeroExt ? {{(XLEN-16){1'b0}}, imm}
                               : {{(XLEN-16){imm[15]}}, imm};
  assign opnd2  = ctrl.useImm ? immExt : rtVal;
  assign sum    = rsVal + opnd2;
  assign diff   = rsVal - opnd2;

  assign addOvf = (rsVal[MSB] == opnd2[MSB]) && (sum[MSB]  != rsVal[MSB]);
  assign subOvf = (rsVal[MSB] != opnd2[MSB]) && (diff[MSB] != rsVal[MSB]);
  assign rawOvf = (ctrl.op == ALU_ADD) ? addOvf :
                  (ctrl.op == ALU_SUB) ? subOvf : 1'b0;

  assign lessThan = ctrl.signedCmp ? ($signed(rsVal) < $signed(opnd2))
                                   : (rsVal < opnd2);

  assign shAmt = ctrl.varShift ? rsVal[SHW-1:0] : SHW'(shamt);

  exec_shifter #(.XLEN(XLEN)) u_shifter (
    .src     (rtVal),
    .amt     (shAmt),
    .dirLeft (ctrl.op == ALU_SLL),
    .arith   (ctrl.op == ALU_SRA),
    .dst     (shiftOut)
  );

  always_comb begin
    unique case (ctrl.op)
      ALU_ADD: result = sum;
      ALU_SUB: result = diff;
      ALU_AND: result = rsVal & opnd2;
      ALU_OR:  result = rsVal | opnd2;
      ALU_XOR: result = rsVal ^ opnd2;
      ALU_NOR: result = ~(rsVal | opnd2);
      ALU_SLT: result = {{(XLEN-1){1'b0}}, lessThan};
      ALU_SLL, ALU_SRL, ALU_SRA: result = shiftOut;
      ALU_LUI: result = {imm, {(XLEN-16){1'b0}}};
      default: result = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({ctrl, rsVal, rtVal, imm}) && ctrl.op == ALU_SLT) begin
      AST_SLT_IS_BOOLEAN: assert (result[XLEN-1:1] == '0); // R6
    end
    if (!$isunknown({ctrl, imm}) && ctrl.op == ALU_LUI) begin
      AST_LUI_LOW_ZERO: assert (result[15:0] == 16'h0 && result[XLEN-1:XLEN-16] == imm); // R9
    end
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instrWord,
  input  logic [XLEN-1:0] rsVal,
  input  logic [XLEN-1:0] rtVal,
  output logic [XLEN-1:0] result,
  output logic            wrEn,
  output logic [4:0]      destIdx,
  output logic            ovfFlag,
  output logic            illegalOp
);

  ctrl_t ctrl;
  logic  rawOvf;

  exec_ctrl u_ctrl (
    .instrWord (instrWord),
    .ctrl      (ctrl)
  );

  exec_datapath #(.XLEN(XLEN)) u_datapath (
    .ctrl   (ctrl),
    .imm    (instrWord[15:0]),
    .shamt  (instrWord[10:6]),
    .rsVal  (rsVal),
    .rtVal  (rtVal),
    .result (result),
    .rawOvf (rawOvf)
  );

  assign illegalOp = !ctrl.legal;
  assign ovfFlag   = ctrl.legal && ctrl.trapOvf && rawOvf;
  assign destIdx   = !ctrl.legal   ? 5'd0 :
                     ctrl.destIsRt ? instrWord[20:16] : instrWord[15:11];
  assign wrEn      = ctrl.legal && !ovfFlag && (destIdx != 5'd0);

  always_comb begin
    if (!$isunknown({instrWord, rsVal, rtVal})) begin
      AST_ZERO_DEST_NO_WRITE: assert (!(wrEn && destIdx == 5'd0)); // R10
      AST_OVERFLOW_NO_WRITE: assert (!(ovfFlag && wrEn)); // R2
      AST_ILLEGAL_QUIET: assert (!(illegalOp && (wrEn || ovfFlag))); // R11
    end
  end

endmodule

// File: tb/test_int_exec_unit.sv
`timescale 1ns/1ps
module test_int_exec_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] rsVal = '0;
  logic [31:0] rtVal = '0;
  logic [31:0] result;
  logic        wrEn;
  logic [4:0]  destIdx;
  logic        ovfFlag;
  logic        illegalOp;

  always #2.5 clk = ~clk;

  int_exec_unit #(.XLEN(32)) i_int_exec_unit (
    .instrWord (instrWord),
    .rsVal     (rsVal),
    .rtVal     (rtVal),
    .result    (result),
    .wrEn      (wrEn),
    .destIdx   (destIdx),
    .ovfFlag   (ovfFlag),
    .illegalOp (illegalOp)
  );

  typedef struct {
    logic [31:0] tag;
    logic [31:0] res;
    logic        chkRes;
    logic        we;
    logic [4:0]  dst;
    logic        ovf;
    logic        ill;
  } exp_t;

  exp_t sbQ[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  function automatic logic [31:0] rIns(logic [4:0] s, logic [4:0] t, logic [4:0] d,
                                       logic [4:0] sh, logic [5:0] fn);
    return {6'h00, s, t, d, sh, fn};
  endfunction

  function automatic logic [31:0] iIns(logic [5:0] op, logic [4:0] s, logic [4:0] t,
                                       logic [15:0] imm);
    return {op, s, t, imm};
  endfunction

  // Driver: applies one instruction and queues what must come out
  task automatic drive(input logic [31:0] tag, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] expRes, input logic chkRes,
                       input logic expWe, input logic [4:0] expDst,
                       input logic expOvf, input logic expIll);
    exp_t e;
    @(posedge clk);
    #1;
    instrWord = ins;
    rsVal     = a;
    rtVal     = b;
    e.tag = tag; e.res = expRes; e.chkRes = chkRes; e.we = expWe;
    e.dst = expDst; e.ovf = expOvf; e.ill = expIll;
    sbQ.push_back(e);
  endtask

  // Monitor: compares the settled outputs between edges
  always @(negedge clk) begin
    if (rstN && sbQ.size() > 0) begin
      exp_t e;
      e = sbQ.pop_front();
      checks++;
      if ((e.chkRes && result !== e.res) || wrEn !== e.we || destIdx !== e.dst ||
          ovfFlag !== e.ovf || illegalOp !== e.ill) begin
        errors++;
        $display("FAIL %s instr=%h actual res=%h we=%b dst=%0d ovf=%b ill=%b expected res=%h we=%b dst=%0d ovf=%b ill=%b",
                 e.tag, instrWord, result, wrEn, destIdx, ovfFlag, illegalOp,
                 e.res, e.we, e.dst, e.ovf, e.ill);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R10: all-zero word after reset is a quiet no-operation
    drive("R10", 32'h0, 32'h0, 32'h0, 32'h0, 1, 0, 5'd0, 0, 0);
    // R1 / R2: register add writes D
    drive("R1", rIns(5'd1, 5'd2, 5'd3, 5'd0, 6'h20), 32'd5, 32'd7, 32'd12, 1, 1, 5'd3, 0, 0);
    // R2: trapping overflow
    drive("R2", rIns(5'd1, 5'd2, 5'd3, 5'd0, 6'h20), 32'h7FFFFFFF, 32'h1, 32'h80000000, 1, 0, 5'd3, 1, 0);
    drive("R2", rIns(5'd1, 5'd2, 5'd4, 5'd0, 6'h22), 32'h80000000, 32'h1, 32'h7FFFFFFF, 1, 0, 5'd4, 1, 0);
    drive("R2", iIns(6'h08, 5'd1, 5'd6, 16'hFFFF), 32'h80000000, 32'h0, 32'h7FFFFFFF, 1, 0, 5'd6, 1, 0);
    drive("R2", rIns(5'd1, 5'd2, 5'd4, 5'd0, 6'h22), 32'd3, 32'd10, 32'hFFFFFFF9, 1, 1, 5'd4, 0, 0);
    // R3: non-trapping forms wrap
    drive("R3", rIns(5'd1, 5'd2, 5'd5, 5'd0, 6'h21), 32'h7FFFFFFF, 32'h1, 32'h80000000, 1, 1, 5'd5, 0, 0);
    drive("R3", rIns(5'd1, 5'd2, 5'd5, 5'd0, 6'h23), 32'h0, 32'h1, 32'hFFFFFFFF, 1, 1, 5'd5, 0, 0);
    drive("R3", iIns(6'h09, 5'd1, 5'd7, 16'h0001), 32'h7FFFFFFF, 32'h0, 32'h80000000, 1, 1, 5'd7, 0, 0);
    // R5 / R1: immediates sign-extend, destination is T
    drive("R5", iIns(6'h08, 5'd4, 5'd9, 16'hFFFF), 32'd10, 32'h0, 32'd9, 1, 1, 5'd9, 0, 0);
    drive("R5", iIns(6'h09, 5'd4, 5'd9, 16'h8000), 32'h0, 32'h0, 32'hFFFF8000, 1, 1, 5'd9, 0, 0);
    // R4: bitwise forms
    drive("R4", rIns(5'd1, 5'd2, 5'd8, 5'd0, 6'h24), 32'hF0F01234, 32'h0FF0FF00, 32'h00F01200, 1, 1, 5'd8, 0, 0);
    drive("R4", rIns(5'd1, 5'd2, 5'd8, 5'd0, 6'h25), 32'hF0F01234, 32'h0FF0FF00, 32'hFFF0FF34, 1, 1, 5'd8, 0, 0);
    drive("R4", rIns(5'd1, 5'd2, 5'd8, 5'd0, 6'h26), 32'hF0F01234, 32'h0FF0FF00, 32'hFF00ED34, 1, 1, 5'd8, 0, 0);
    drive("R4", rIns(5'd1, 5'd2, 5'd8, 5'd0, 6'h27), 32'h0F0F0000, 32'h000000FF, 32'hF0F0FF00, 1, 1, 5'd8, 0, 0);
    drive("R4", iIns(6'h0C, 5'd1, 5'd10, 16'h8001), 32'hFFFFFFFF, 32'h0, 32'h00008001, 1, 1, 5'd10, 0, 0);
    drive("R4", iIns(6'h0D, 5'd1, 5'd10, 16'hFFFF), 32'h12340000, 32'h0, 32'h1234FFFF, 1, 1, 5'd10, 0, 0);
    drive("R4", iIns(6'h0E, 5'd1, 5'd10, 16'hFFFF), 32'hFFFF0000, 32'h0, 32'hFFFFFFFF, 1, 1, 5'd10, 0, 0);
    // R6: compares
    drive("R6", rIns(5'd1, 5'd2, 5'd11, 5'd0, 6'h2A), 32'hFFFFFFFF, 32'h1, 32'h1, 1, 1, 5'd11, 0, 0);
    drive("R6", rIns(5'd1, 5'd2, 5'd11, 5'd0, 6'h2B), 32'hFFFFFFFF, 32'h1, 32'h0, 1, 1, 5'd11, 0, 0);
    drive("R6", iIns(6'h0A, 5'd1, 5'd12, 16'hFFFF), 32'hFFFFFFFE, 32'h0, 32'h1, 1, 1, 5'd12, 0, 0);
    drive("R6", iIns(6'h0A, 5'd1, 5'd12, 16'h0005), 32'd5, 32'h0, 32'h0, 1, 1, 5'd12, 0, 0);
    drive("R6", iIns(6'h0B, 5'd1, 5'd12, 16'hFFFF), 32'd5, 32'h0, 32'h1, 1, 1, 5'd12, 0, 0);
    drive("R6", iIns(6'h0B, 5'd1, 5'd12, 16'hFFFF), 32'hFFFFFFFF, 32'h0, 32'h0, 1, 1, 5'd12, 0, 0);
    // R7 / R1: constant shifts, S field and rsVal ignored
    drive("R7", rIns(5'd5, 5'd2, 5'd13, 5'd31, 6'h00), 32'hFFFFFFFF, 32'h1, 32'h80000000, 1, 1, 5'd13, 0, 0);
    drive("R7", rIns(5'd5, 5'd2, 5'd13, 5'd4, 6'h02), 32'hFFFFFFFF, 32'h80000000, 32'h08000000, 1, 1, 5'd13, 0, 0);
    drive("R7", rIns(5'd5, 5'd2, 5'd13, 5'd4, 6'h03), 32'h0, 32'h80000000, 32'hF8000000, 1, 1, 5'd13, 0, 0);
    drive("R7", rIns(5'd0, 5'd2, 5'd13, 5'd30, 6'h03), 32'h0, 32'h40000000, 32'h1, 1, 1, 5'd13, 0, 0);
    // R8: variable shifts use rsVal[4:0], shift-amount field ignored
    drive("R8", rIns(5'd1, 5'd2, 5'd14, 5'd7, 6'h04), 32'h00000024, 32'h1, 32'h10, 1, 1, 5'd14, 0, 0);
    drive("R8", rIns(5'd1, 5'd2, 5'd14, 5'd7, 6'h06), 32'hFFFFFFE3, 32'h80, 32'h10, 1, 1, 5'd14, 0, 0);
    drive("R8", rIns(5'd1, 5'd2, 5'd14, 5'd7, 6'h07), 32'h00000021, 32'h80000000, 32'hC0000000, 1, 1, 5'd14, 0, 0);
    drive("R8", rIns(5'd1, 5'd2, 5'd14, 5'd3, 6'h06), 32'h00000020, 32'h80000000, 32'h80000000, 1, 1, 5'd14, 0, 0);
    // R9: upper immediate
    drive("R9", iIns(6'h0F, 5'd3, 5'd15, 16'hABCD), 32'hFFFFFFFF, 32'h0, 32'hABCD0000, 1, 1, 5'd15, 0, 0);
    // R10: destination zero suppresses write
    drive("R10", rIns(5'd1, 5'd2, 5'd0, 5'd0, 6'h20), 32'd1, 32'd2, 32'd3, 1, 0, 5'd0, 0, 0);
    drive("R10", iIns(6'h0D, 5'd1, 5'd0, 16'h00FF), 32'h0, 32'h0, 32'h000000FF, 1, 0, 5'd0, 0, 0);
    // R11: unsupported encodings
    drive("R11", iIns(6'h23, 5'd1, 5'd2, 16'h0004), 32'h7FFFFFFF, 32'h1, 32'h0, 0, 0, 5'd0, 0, 1);
    drive("R11", rIns(5'd1, 5'd2, 5'd3, 5'd0, 6'h18), 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h0, 0, 0, 5'd0, 0, 1);
    drive("R11", rIns(5'd1, 5'd0, 5'd0, 5'd0, 6'h08), 32'h1, 32'h0, 32'h0, 0, 0, 5'd0, 0, 1);
    drive("R11", rIns(5'd1, 5'd2, 5'd3, 5'd0, 6'h01), 32'h1, 32'h2, 32'h0, 0, 0, 5'd0, 0, 1);

    while (sbQ.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule